// File: doc/BRIEF.md
# Clock Distribution Controller with Demand-Driven Gating and Crystal Fail-Safe

This block routes five oscillator sources to three system clocks: an auxiliary clock, a master clock and a subsystem clock. All logic runs on one fast reference clock. Each oscillator arrives as a one-cycle tick strobe in that domain, and each system clock leaves as a tick strobe that downstream logic uses as a clock enable. The five sources are a low-frequency crystal, a high-frequency crystal, a very-low-power oscillator, a module oscillator and a digitally controlled oscillator. A sixth, derived source gives one tick for every 128 module-oscillator ticks. It serves as the fail-safe for the low-frequency crystal.

Software picks a source for each output through plain select inputs. A low-power mode input gates outputs level by level. Each output has a peripheral request line, and when its request handling is enabled that line keeps the output running in any mode. Two crystal fault inputs each replace their crystal with a fail-safe source for as long as the fault is present. Each fault also sets a sticky flag that software clears by writing 1. An output whose effective source changes stays silent for a short gap before the new source is passed on, so the old and new sources never overlap.

Top module: `clkdist_top`

## Requirements
- R1: `aclk_sel` picks the auxiliary source: 0 = low-frequency crystal, 1 = very-low-power oscillator, 2 or 3 = divided module clock.
- R2: `mclk_sel` and `smclk_sel` each pick a source: 0 = low-frequency crystal, 1 = very-low-power oscillator, 2 = divided module clock, 3 = digitally controlled oscillator, 4 = module oscillator, 5 = high-frequency crystal, 6 or 7 = digitally controlled oscillator. An output ticks in the cycle after each tick of its effective source.
- R3: The divided module clock gives one tick for every 128 module-oscillator ticks. Its counter is held at zero while no output's effective source is the divided clock. After that source becomes effective at a clock edge, its first tick appears on the output 128 edges later (module oscillator ticking every cycle).
- R4: While `vlo_off` is 1, the very-low-power source gives no ticks to any output.
- R5: `lpm_mode` gates the outputs. A value of 1 or more stops the master clock, 3 or more stops the subsystem clock, and 4 or more stops the auxiliary clock. Mode 0 leaves all three running. A gated output stays low from the cycle after the gating condition holds.
- R6: When `req_en[i]` and `clk_req[i]` are both 1, output i (bit 0 = auxiliary, 1 = master, 2 = subsystem) runs regardless of `lpm_mode`. With `req_en[i]` at 0, the request has no effect.
- R7: While `lfxt_fault` is 1, any output whose source is the low-frequency crystal is fed from the divided module clock. Once the fault is removed, the crystal is used again.
- R8: While `hfxt_fault` is 1, any output whose source is the high-frequency crystal is fed from the undivided module oscillator.
- R9: `fault_flag[0]` (low-frequency) and `fault_flag[1]` (high-frequency) are set one cycle after their fault input is high. Each stays set until a cycle in which its `fault_clr` bit is 1 and its fault input is 0; a present fault wins over a clear.
- R10: When an output's effective source changes, that output stays low for GAP+1 cycles (3 by default). After that it follows the new source.
- R11: While `rst_n` is 0, all tick outputs and both fault flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock for all logic |
| rst_n | input | 1 | Active-low synchronous reset |
| lfxt_tick | input | 1 | Low-frequency crystal tick strobe |
| hfxt_tick | input | 1 | High-frequency crystal tick strobe |
| vlo_tick | input | 1 | Very-low-power oscillator tick strobe |
| mod_tick | input | 1 | Module oscillator tick strobe |
| dco_tick | input | 1 | Digitally controlled oscillator tick strobe |
| vlo_off | input | 1 | Disables the very-low-power source |
| aclk_sel | input | 2 | Auxiliary clock source select |
| mclk_sel | input | 3 | Master clock source select |
| smclk_sel | input | 3 | Subsystem clock source select |
| lpm_mode | input | 3 | Current low-power mode level |
| clk_req | input | 3 | Peripheral clock requests per output |
| req_en | input | 3 | Request handling enable per output |
| lfxt_fault | input | 1 | Low-frequency crystal fault indication |
| hfxt_fault | input | 1 | High-frequency crystal fault indication |
| fault_clr | input | 2 | Write-1-to-clear strobes for the fault flags |
| aclk_tick | output | 1 | Auxiliary clock enable strobe |
| mclk_tick | output | 1 | Master clock enable strobe |
| smclk_tick | output | 1 | Subsystem clock enable strobe |
| fault_flag | output | 2 | Sticky crystal fault flags |

## Verification
Internal errors show up as wrong tick counts on an output. A select leg latched on the wrong source, a stuck gap counter or a missed substitution changes the count within one window of a few hundred cycles. A divider that runs when it should be idle, or that does not clear, moves the first divided tick away from edge 128 after selection. The bench detects that to the exact cycle. A wrong break-before-make sequence puts a tick within the first three cycles after a source change, and flag errors appear one cycle after the fault or clear stimulus.

// File: rtl/clkdist_pkg.sv
package clkdist_pkg;
    localparam int SEL_W = 3;
    localparam int NPAD  = 1 << SEL_W;
    localparam int NOUT  = 3;
    localparam int OUT_A = 0;
    localparam int OUT_M = 1;
    localparam int OUT_S = 2;

    localparam logic [2:0] LPM_M_OFF = 3'd1;
    localparam logic [2:0] LPM_S_OFF = 3'd3;
    localparam logic [2:0] LPM_A_OFF = 3'd4;

    typedef enum logic [SEL_W-1:0] {
        SRC_LFXT  = 3'd0,
        SRC_VLO   = 3'd1,
        SRC_LFMOD = 3'd2,
        SRC_DCO   = 3'd3,
        SRC_MOD   = 3'd4,
        SRC_HFXT  = 3'd5
    } src_e;

    function automatic src_e aux_src(input logic [1:0] v);
        case (v)
            2'd0:    return SRC_LFXT;
            2'd1:    return SRC_VLO;
            default: return SRC_LFMOD;
        endcase
    endfunction

    function automatic src_e main_src(input logic [SEL_W-1:0] v);
        case (v)
            3'd0:    return SRC_LFXT;
            3'd1:    return SRC_VLO;
            3'd2:    return SRC_LFMOD;
            3'd4:    return SRC_MOD;
            3'd5:    return SRC_HFXT;
            default: return SRC_DCO;
        endcase
    endfunction

    function automatic src_e fail_safe(input src_e s, input logic lf_bad, input logic hf_bad);
        if (s == SRC_LFXT && lf_bad) return SRC_LFMOD;
        if (s == SRC_HFXT && hf_bad) return SRC_MOD;
        return s;
    endfunction
endpackage

// File: rtl/clkdist_div.sv
module clkdist_div #(
    parameter int DIV_W = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic mod_tick,
    output logic tick_o
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } div_st_t;

    div_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        tick_o = run && mod_tick && (st_q.cnt == '1);
        if (!run)          st_d.cnt = '0;
        else if (mod_tick) st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: divided ticks are never back to back
    p_div_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    // R3: an idle divider produces nothing in the following cycle
    p_div_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !tick_o);
endmodule

// File: rtl/clkdist_leg.sv
module clkdist_leg
    import clkdist_pkg::*;
#(
    parameter int GAP = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPAD-1:0]  src_ticks,
    input  logic [SEL_W-1:0] sel,
    input  logic             run,
    output logic             tick_o
);
    localparam int GAP_W = $clog2(GAP + 1);

    typedef struct packed {
        logic [SEL_W-1:0] cur;
        logic [GAP_W-1:0] gap;
        logic             tick;
    } leg_st_t;

    leg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sel != st_q.cur) begin
            st_d.cur  = sel;
            st_d.gap  = GAP_W'(GAP);
            st_d.tick = 1'b0;
        end else if (st_q.gap != '0) begin
            st_d.gap  = st_q.gap - 1'b1;
            st_d.tick = 1'b0;
        end else begin
            st_d.tick = src_ticks[st_q.cur] && run;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_o = st_q.tick;

    // R10: a source change silences the output in the next cycle
    p_switch_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sel != st_q.cur) |=> !tick_o);
    // R10: no tick while the gap is still counting down
    p_gap_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.gap != '0) |=> !tick_o);
endmodule

// File: rtl/clkdist_top.sv
module clkdist_top
    import clkdist_pkg::*;
#(
    parameter int DIV_W = 7,
    parameter int GAP   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lfxt_tick,
    input  logic       hfxt_tick,
    input  logic       vlo_tick,
    input  logic       mod_tick,
    input  logic       dco_tick,
    input  logic       vlo_off,
    input  logic [1:0] aclk_sel,
    input  logic [2:0] mclk_sel,
    input  logic [2:0] smclk_sel,
    input  logic [2:0] lpm_mode,
    input  logic [2:0] clk_req,
    input  logic [2:0] req_en,
    input  logic       lfxt_fault,
    input  logic       hfxt_fault,
    input  logic [1:0] fault_clr,
    output logic       aclk_tick,
    output logic       mclk_tick,
    output logic       smclk_tick,
    output logic [1:0] fault_flag
);
    typedef struct packed {
        logic [1:0] flag;
    } top_st_t;

    top_st_t st_d, st_q;

    src_e            eff_sel [NOUT];
    logic [NOUT-1:0] gate;
    logic [NOUT-1:0] run;
    logic [NOUT-1:0] outs;
    logic [NPAD-1:0] srcv;
    logic            div_run;
    logic            lfmod_tick;

    always_comb begin
        eff_sel[OUT_A] = fail_safe(aux_src(aclk_sel), lfxt_fault, hfxt_fault);
        eff_sel[OUT_M] = fail_safe(main_src(mclk_sel), lfxt_fault, hfxt_fault);
        eff_sel[OUT_S] = fail_safe(main_src(smclk_sel), lfxt_fault, hfxt_fault);

        div_run = 1'b0;
        for (int i = 0; i < NOUT; i++)
            if (eff_sel[i] == SRC_LFMOD) div_run = 1'b1;

        gate[OUT_A] = (lpm_mode >= LPM_A_OFF);
        gate[OUT_M] = (lpm_mode >= LPM_M_OFF);
        gate[OUT_S] = (lpm_mode >= LPM_S_OFF);
        run = ~gate | (req_en & clk_req);

        srcv            = '0;
        srcv[SRC_LFXT]  = lfxt_tick;
        srcv[SRC_VLO]   = vlo_tick && !vlo_off;
        srcv[SRC_LFMOD] = lfmod_tick;
        srcv[SRC_DCO]   = dco_tick;
        srcv[SRC_MOD]   = mod_tick;
        srcv[SRC_HFXT]  = hfxt_tick;

        st_d.flag = {hfxt_fault, lfxt_fault} | (st_q.flag & ~fault_clr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    clkdist_div #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (div_run),
        .mod_tick (mod_tick),
        .tick_o   (lfmod_tick)
    );

    for (genvar g = 0; g < NOUT; g++) begin : g_leg
        clkdist_leg #(.GAP(GAP)) u_leg (
            .clk       (clk),
            .rst_n     (rst_n),
            .src_ticks (srcv),
            .sel       (eff_sel[g]),
            .run       (run[g]),
            .tick_o    (outs[g])
        );
    end

    assign aclk_tick  = outs[OUT_A];
    assign mclk_tick  = outs[OUT_M];
    assign smclk_tick = outs[OUT_S];
    assign fault_flag = st_q.flag;

    // R5/R6: gated and not requested means silent next cycle
    p_aclk_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lpm_mode >= 3'd4 && !(req_en[0] && clk_req[0])) |=> !aclk_tick);
    p_mclk_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lpm_mode >= 3'd1 && !(req_en[1] && clk_req[1])) |=> !mclk_tick);
    p_smclk_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lpm_mode >= 3'd3 && !(req_en[2] && clk_req[2])) |=> !smclk_tick);
    // R4: a disabled very-low-power source never reaches the auxiliary clock
    p_vlo_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (vlo_off && aclk_sel == 2'd1) |=> !aclk_tick);
    // R9: fault sets flag, flag holds without a clear
    p_flag_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lfxt_fault |=> fault_flag[0]);
    p_flag_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_flag[1] && !fault_clr[1]) |=> fault_flag[1]);
endmodule

// File: tb/clkdist_top_test.sv
`timescale 1ns/1ps
module clkdist_top_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lfxt_tick = 1'b0, hfxt_tick = 1'b0, vlo_tick = 1'b0;
    logic       mod_tick = 1'b0, dco_tick = 1'b0;
    logic       vlo_off = 1'b0;
    logic [1:0] aclk_sel = 2'd0;
    logic [2:0] mclk_sel = 3'd3, smclk_sel = 3'd3;
    logic [2:0] lpm_mode = 3'd0, clk_req = 3'd0, req_en = 3'd0;
    logic       lfxt_fault = 1'b0, hfxt_fault = 1'b0;
    logic [1:0] fault_clr = 2'd0;
    logic       aclk_tick, mclk_tick, smclk_tick;
    logic [1:0] fault_flag;

    int checks = 0;
    int errors = 0;
    int phase  = 0;

    always #4 clk = ~clk;

    clkdist_top uut (
        .clk(clk), .rst_n(rst_n),
        .lfxt_tick(lfxt_tick), .hfxt_tick(hfxt_tick), .vlo_tick(vlo_tick),
        .mod_tick(mod_tick), .dco_tick(dco_tick), .vlo_off(vlo_off),
        .aclk_sel(aclk_sel), .mclk_sel(mclk_sel), .smclk_sel(smclk_sel),
        .lpm_mode(lpm_mode), .clk_req(clk_req), .req_en(req_en),
        .lfxt_fault(lfxt_fault), .hfxt_fault(hfxt_fault), .fault_clr(fault_clr),
        .aclk_tick(aclk_tick), .mclk_tick(mclk_tick), .smclk_tick(smclk_tick),
        .fault_flag(fault_flag)
    );

    // Source periods: lfxt 4, vlo 8, dco 3, hfxt 2, mod 1
    initial forever begin
        @(negedge clk);
        phase++;
        lfxt_tick = (phase % 4 == 0);
        vlo_tick  = (phase % 8 == 0);
        dco_tick  = (phase % 3 == 0);
        hfxt_tick = (phase % 2 == 0);
        mod_tick  = 1'b1;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic measure(input int n, output int a, output int m, output int s);
        a = 0; m = 0; s = 0;
        repeat (n) begin
            @(negedge clk);
            a += int'(aclk_tick);
            m += int'(mclk_tick);
            s += int'(smclk_tick);
        end
    endtask

    task automatic t_reset();
        settle(5);
        chk("R11 aclk in reset", int'(aclk_tick), 0);
        chk("R11 mclk in reset", int'(mclk_tick), 0);
        chk("R11 smclk in reset", int'(smclk_tick), 0);
        chk("R11 flags in reset", int'(fault_flag), 0);
        rst_n = 1'b1;
        settle(10);
    endtask

    task automatic t_div_start();
        int first = -1;
        aclk_sel = 2'd2;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (aclk_tick && first < 0) first = i;
        end
        chk("R3 first divided tick edge", first, 127);
        aclk_sel = 2'd0;
        settle(8);
    endtask

    task automatic t_aclk_src();
        int a, m, s;
        aclk_sel = 2'd0; settle(8); measure(240, a, m, s);
        chk("R1 aclk lfxt", a, 60);
        aclk_sel = 2'd1; settle(8); measure(240, a, m, s);
        chk("R1 aclk vlo", a, 30);
        aclk_sel = 2'd2; settle(8); measure(256, a, m, s);
        chk("R1 aclk divided", a, 2);
        aclk_sel = 2'd3; settle(8); measure(256, a, m, s);
        chk("R1 aclk sel3 divided", a, 2);
        aclk_sel = 2'd0; settle(8);
    endtask

    task automatic t_main_src();
        int a, m, s;
        mclk_sel = 3'd3; smclk_sel = 3'd1; settle(8); measure(240, a, m, s);
        chk("R2 mclk dco", m, 80);
        chk("R2 smclk vlo", s, 30);
        mclk_sel = 3'd4; smclk_sel = 3'd0; settle(8); measure(240, a, m, s);
        chk("R2 mclk mod", m, 240);
        chk("R2 smclk lfxt", s, 60);
        mclk_sel = 3'd5; smclk_sel = 3'd7; settle(8); measure(240, a, m, s);
        chk("R2 mclk hfxt", m, 120);
        chk("R2 smclk sel7 dco", s, 80);
        mclk_sel = 3'd2; settle(8); measure(256, a, m, s);
        chk("R2 mclk divided", m, 2);
        mclk_sel = 3'd3; smclk_sel = 3'd5; settle(8);
    endtask

    task automatic t_vlo_off();
        int a, m, s;
        aclk_sel = 2'd1; vlo_off = 1'b1; settle(8); measure(240, a, m, s);
        chk("R4 vlo off aclk", a, 0);
        vlo_off = 1'b0; settle(8); measure(240, a, m, s);
        chk("R4 vlo back on aclk", a, 30);
        aclk_sel = 2'd0; settle(8);
    endtask

    task automatic t_lpm();
        int a, m, s;
        lpm_mode = 3'd1; settle(4); measure(240, a, m, s);
        chk("R5 lpm1 aclk", a, 60); chk("R5 lpm1 mclk", m, 0); chk("R5 lpm1 smclk", s, 120);
        lpm_mode = 3'd3; settle(4); measure(240, a, m, s);
        chk("R5 lpm3 aclk", a, 60); chk("R5 lpm3 smclk", s, 0);
        lpm_mode = 3'd4; settle(4); measure(240, a, m, s);
        chk("R5 lpm4 all", a + m + s, 0);
        lpm_mode = 3'd0; settle(4); measure(240, a, m, s);
        chk("R5 active aclk", a, 60); chk("R5 active mclk", m, 80); chk("R5 active smclk", s, 120);
    endtask

    task automatic t_req();
        int a, m, s;
        lpm_mode = 3'd3; clk_req = 3'b100; req_en = 3'b100; settle(4); measure(240, a, m, s);
        chk("R6 smclk requested in lpm3", s, 120);
        chk("R6 mclk not requested", m, 0);
        req_en = 3'b000; settle(4); measure(240, a, m, s);
        chk("R6 request disabled smclk", s, 0);
        lpm_mode = 3'd4; clk_req = 3'b001; req_en = 3'b001; settle(4); measure(240, a, m, s);
        chk("R6 aclk requested in lpm4", a, 60);
        lpm_mode = 3'd0; clk_req = 3'b000; req_en = 3'b000; settle(4);
    endtask

    task automatic t_lf_fault();
        int a, m, s;
        aclk_sel = 2'd0; lfxt_fault = 1'b1; settle(8); measure(256, a, m, s);
        chk("R7 aclk on divided during fault", a, 2);
        chk("R9 lf flag set", int'(fault_flag[0]), 1);
        chk("R9 hf flag untouched", int'(fault_flag[1]), 0);
        lfxt_fault = 1'b0; settle(8); measure(240, a, m, s);
        chk("R7 aclk back on crystal", a, 60);
        chk("R9 lf flag sticky", int'(fault_flag[0]), 1);
        fault_clr = 2'b01; settle(1); fault_clr = 2'b00; settle(1);
        chk("R9 lf flag cleared", int'(fault_flag[0]), 0);
    endtask

    task automatic t_hf_fault();
        int a, m, s;
        mclk_sel = 3'd5; hfxt_fault = 1'b1; settle(8); measure(240, a, m, s);
        chk("R8 mclk on module osc during fault", m, 240);
        chk("R8 smclk on module osc during fault", s, 240);
        chk("R9 hf flag set", int'(fault_flag[1]), 1);
        fault_clr = 2'b10; settle(1); fault_clr = 2'b00; settle(1);
        chk("R9 hf clear loses to fault", int'(fault_flag[1]), 1);
        hfxt_fault = 1'b0; settle(8); measure(240, a, m, s);
        chk("R8 mclk back on crystal", m, 120);
        fault_clr = 2'b10; settle(1); fault_clr = 2'b00; settle(1);
        chk("R9 hf flag cleared", int'(fault_flag[1]), 0);
        mclk_sel = 3'd3; settle(8);
    endtask

    task automatic t_switch();
        int z = 0;
        mclk_sel = 3'd3; settle(8);
        mclk_sel = 3'd4;
        repeat (3) begin
            @(negedge clk);
            z += int'(mclk_tick);
        end
        chk("R10 gap silent cycles", z, 0);
        @(negedge clk);
        chk("R10 new source after gap", int'(mclk_tick), 1);
        mclk_sel = 3'd3; settle(8);
    endtask

    initial begin
        t_reset();
        t_div_start();
        t_aclk_src();
        t_main_src();
        t_vlo_off();
        t_lpm();
        t_req();
        t_lf_fault();
        t_hf_fault();
        t_switch();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule